// File: doc/BRIEF.md
# Trigger event bunch packer

This block gathers timestamped trigger events into self-contained bunches and hands each bunch to a downstream datagram framer as a byte stream with valid/ready flow control. Each accepted trigger strobe captures the current time fields, the serial side-channel value, the low bits of the run counters and two status flags into one 96-bit event word. These words go into an on-chip slot buffer. A bunch closes when the buffer holds `MAX_EVENTS` words, or when `TIMEOUT_CYC` cycles have passed since the previous bunch left. The event words then go out, followed by a 160-bit tailer that carries the full-width counters, the bunch number, status flags and a version byte.

While the counter-enable input is low, the block is in standby. It stores no events and sends only a tailer, with zeroed counters, once per timeout period.

A throttle limits storage when triggers arrive densely. After the first event of a bunch, further events are stored only once more than `thr_ticks` cycles have passed since that first event. Strobes that are throttled away still update the counters that the tailer reports. The value 0xFFFF switches the throttle off.

Top module: `evt_bunch_packer`

## Requirements
- R1: Each event word is laid out as follows, and is sent most significant byte first (12 bytes), in the order the events were stored:
  - [95:80] serial value
  - [79:72] read-out count bits 7:0
  - [71:64] busy count bits 7:0
  - [63:62] pulse-per-second count bits 1:0
  - [61:60] seconds bits 1:0
  - [59] busy flag
  - [58] time-valid flag
  - [57:32] 26-bit cycle count
  - [31:4] 28-bit 8 ns tag
  - [3] zero
  - [2:0] fine 1 ns value
- R2: When the `MAX_EVENTS`-th event is stored, the bunch closes at once. The bunch is `MAX_EVENTS`*12+20 bytes long, and `m_last` is high only on its final byte.
- R3: The 20-byte tailer follows the events, most significant byte first, laid out as follows:
  - [159:128] bunch number
  - [127:96] read-out count
  - [95:64] busy count
  - [63:48] 16-bit pulse-per-second count
  - [47:16] 32-bit seconds
  - [15] `time_valid` at close
  - [14] `cnt_en` at close
  - [13:8] zero
  - [7:0] `VERSION`
- R4: A bunch that is not full closes after exactly `TIMEOUT_CYC` cycles without `m_valid`, counted from the cycle after the final byte of the previous bunch is accepted. If no event was stored, the bunch is the tailer alone.
- R5: While `cnt_en` is low, strobes are not stored and the tailer counters read zero, with bit 14 cleared.
- R6: With `thr_ticks` other than 0xFFFF, a strobe that comes k cycles after the first stored event of the bunch is stored only if k > `thr_ticks`. A throttled strobe still updates the tailer counters. With 0xFFFF, strobes on consecutive cycles are all stored.
- R7: The tailer seconds come from the last strobe that had `busy_flag` low. The other tailer counters come from the last strobe of either kind.
- R8: The bunch number starts at 0 after reset and rises by one for each bunch sent.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` holds its value.
- R10: A strobe that arrives while a bunch is being sent is neither stored nor reflected in any tailer.
- R11: A strobe in the cycle in which the timeout expires is stored and included in the bunch that closes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_stb | input | 1 | One-cycle trigger strobe |
| ts_tag8 | input | 28 | 8 ns timestamp within the second |
| ts_fine | input | 3 | 1 ns fine timestamp |
| clk_cnt | input | 26 | Free-running cycle count |
| spi_data | input | 16 | Serial side-channel value for this trigger |
| ro_cnt | input | 32 | Read-out event count |
| busy_cnt | input | 32 | Busy event count |
| pps_cnt | input | 16 | Pulse-per-second count |
| secs | input | 32 | Seconds of absolute time |
| busy_flag | input | 1 | Trigger arrived while busy |
| time_valid | input | 1 | Local time locked to master |
| cnt_en | input | 1 | Counters running (high) or standby (low) |
| thr_ticks | input | 16 | Throttle window in cycles, 0xFFFF = off |
| m_ready | input | 1 | Downstream accepts a byte |
| m_valid | output | 1 | Payload byte valid |
| m_data | output | 8 | Payload byte |
| m_last | output | 1 | Final byte of a bunch |

## Verification
Two functions can meet in one cycle: the timeout expiring, and a strobe being stored. The bench aligns a strobe to the exact expiry cycle by counting cycles from the final accepted byte of the previous bunch. It then expects that event inside the bunch that closes. A second strobe one cycle later lands in the first sending cycle. It must be absent from that bunch and from the next tailer's counters. A similar meeting happens between the fill that completes a bunch and the throttle window ending; the throttle scenarios place a strobe one cycle before and exactly at the window boundary.

// File: rtl/ebp_pkg.sv
package ebp_pkg;

  localparam int EV_BYTES = 12;
  localparam int TL_BYTES = 20;

  typedef enum logic {ST_COLLECT, ST_SEND} ebp_state_t;

  function automatic logic [95:0] pack_event(
    input logic [15:0] spi,
    input logic [7:0]  ro8,
    input logic [7:0]  bz8,
    input logic [1:0]  pps2,
    input logic [1:0]  sec2,
    input logic        bflag,
    input logic        tvalid,
    input logic [25:0] cyc,
    input logic [27:0] tag8,
    input logic [2:0]  fine
  );
    return {spi, ro8, bz8, pps2, sec2, bflag, tvalid, cyc, tag8, 1'b0, fine};
  endfunction

  function automatic logic [159:0] pack_tailer(
    input logic [31:0] bunch,
    input logic [31:0] ro,
    input logic [31:0] bz,
    input logic [15:0] pps,
    input logic [31:0] sec,
    input logic        tvalid,
    input logic        run,
    input logic [7:0]  ver
  );
    return {bunch, ro, bz, pps, sec, tvalid, run, 6'b0, ver};
  endfunction

  // top byte after shifting out k leading bytes
  function automatic logic [7:0] event_byte(input logic [95:0] w, input logic [4:0] k);
    logic [95:0] s;
    s = w << (8 * int'(k));
    return s[95:88];
  endfunction

  function automatic logic [7:0] tailer_byte(input logic [159:0] w, input logic [4:0] k);
    logic [159:0] s;
    s = w << (8 * int'(k));
    return s[159:152];
  endfunction

endpackage

// File: rtl/ebp_throttle.sv
module ebp_throttle #(
  parameter int W = 16
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] window,
  output logic         pass
);
  logic [W-1:0] left_q;
  logic         off;

  assign off  = &window;
  assign pass = off | (left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)              left_q <= '0;
    else if (load)           left_q <= window;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/ebp_timer.sv
module ebp_timer #(
  parameter int LIMIT = 625000
)(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign hit = run & (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || hit) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ebp_byte_seq.sv
module ebp_byte_seq #(
  parameter int NW = 5
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          adv,
  input  logic [NW-1:0] nev,
  output logic          in_tail,
  output logic [NW-1:0] ev_idx,
  output logic [4:0]    by_idx,
  output logic          last
);
  import ebp_pkg::*;

  assign in_tail = (ev_idx == nev);
  assign last    = in_tail & (by_idx == 5'(TL_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      ev_idx <= '0;
      by_idx <= '0;
    end else if (adv) begin
      if (in_tail) begin
        by_idx <= by_idx + 1'b1;
      end else if (by_idx == 5'(EV_BYTES - 1)) begin
        by_idx <= '0;
        ev_idx <= ev_idx + 1'b1;
      end else begin
        by_idx <= by_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_bunch_packer.sv
module evt_bunch_packer
  import ebp_pkg::*;
#(
  parameter int         MAX_EVENTS  = 24,
  parameter int         TIMEOUT_CYC = 625000,
  parameter logic [7:0] VERSION     = 8'h06
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trig_stb,
  input  logic [27:0] ts_tag8,
  input  logic [2:0]  ts_fine,
  input  logic [25:0] clk_cnt,
  input  logic [15:0] spi_data,
  input  logic [31:0] ro_cnt,
  input  logic [31:0] busy_cnt,
  input  logic [15:0] pps_cnt,
  input  logic [31:0] secs,
  input  logic        busy_flag,
  input  logic        time_valid,
  input  logic        cnt_en,
  input  logic [15:0] thr_ticks,
  input  logic        m_ready,
  output logic        m_valid,
  output logic [7:0]  m_data,
  output logic        m_last
);
  localparam int NW = $clog2(MAX_EVENTS + 1);

  ebp_state_t  st_q;
  logic [NW-1:0] nev_q, nev_nx;
  logic [95:0] slot_q [MAX_EVENTS];
  logic [95:0] ev_word, ev_sel;
  logic [31:0] bunch_q;
  logic [159:0] tail_q;
  logic [31:0] last_ro_q, last_bz_q, last_sec_q, ro_nx, bz_nx, sec_nx;
  logic [15:0] last_pps_q, pps_nx;

  // named internal events
  logic collecting, upd_evt, first_evt, room, thr_pass, store_evt;
  logic tmo_hit, close_bunch, send_beat, send_done;
  logic in_tail, seq_last;
  logic [NW-1:0] ev_idx;
  logic [4:0] by_idx;

  assign collecting  = (st_q == ST_COLLECT);
  assign upd_evt     = trig_stb & cnt_en & collecting;
  assign first_evt   = (nev_q == '0);
  assign room        = (nev_q < NW'(MAX_EVENTS));
  assign store_evt   = upd_evt & room & (first_evt | thr_pass);
  assign nev_nx      = nev_q + NW'(store_evt);
  assign close_bunch = collecting & ((nev_nx == NW'(MAX_EVENTS)) | tmo_hit);
  assign send_beat   = m_valid & m_ready;
  assign send_done   = send_beat & seq_last;

  assign ev_word = pack_event(spi_data, ro_cnt[7:0], busy_cnt[7:0], pps_cnt[1:0],
                              secs[1:0], busy_flag, time_valid, clk_cnt, ts_tag8, ts_fine);

  ebp_throttle #(.W(16)) u_thr (
    .clk(clk), .rst_n(rst_n), .load(store_evt & first_evt),
    .window(thr_ticks), .pass(thr_pass));

  ebp_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run(collecting), .hit(tmo_hit));

  ebp_byte_seq #(.NW(NW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(close_bunch), .adv(send_beat), .nev(nev_q),
    .in_tail(in_tail), .ev_idx(ev_idx), .by_idx(by_idx), .last(seq_last));

  // counters that the tailer reports, including this cycle's strobe
  always_comb begin
    ro_nx  = last_ro_q;
    bz_nx  = last_bz_q;
    pps_nx = last_pps_q;
    sec_nx = last_sec_q;
    if (!cnt_en) begin
      ro_nx = '0; bz_nx = '0; pps_nx = '0; sec_nx = '0;
    end else if (upd_evt) begin
      ro_nx  = ro_cnt;
      bz_nx  = busy_cnt;
      pps_nx = pps_cnt;
      if (!busy_flag) sec_nx = secs;
    end
  end

  for (genvar g = 0; g < MAX_EVENTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (store_evt && nev_q == NW'(g)) slot_q[g] <= ev_word;
    end
  end

  always_comb begin
    ev_sel = '0;
    for (int i = 0; i < MAX_EVENTS; i++) begin
      if (ev_idx == NW'(i)) ev_sel = slot_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_COLLECT;
      nev_q      <= '0;
      bunch_q    <= '0;
      tail_q     <= '0;
      last_ro_q  <= '0;
      last_bz_q  <= '0;
      last_pps_q <= '0;
      last_sec_q <= '0;
    end else begin
      last_ro_q  <= ro_nx;
      last_bz_q  <= bz_nx;
      last_pps_q <= pps_nx;
      last_sec_q <= sec_nx;
      if (collecting) begin
        nev_q <= nev_nx;
        if (close_bunch) begin
          st_q   <= ST_SEND;
          tail_q <= pack_tailer(bunch_q, ro_nx, bz_nx, pps_nx, sec_nx,
                                time_valid, cnt_en, VERSION);
        end
      end else if (send_done) begin
        st_q    <= ST_COLLECT;
        nev_q   <= '0;
        bunch_q <= bunch_q + 1'b1;
      end
    end
  end

  assign m_valid = (st_q == ST_SEND);
  assign m_last  = m_valid & seq_last;
  assign m_data  = in_tail ? tailer_byte(tail_q, by_idx) : event_byte(ev_sel, by_idx);

endmodule

// File: rtl/ebp_checker.sv
module ebp_checker #(
  parameter int MAX_EVENTS = 24
)(
  input logic                             clk,
  input logic                             rst_n,
  input logic                             m_valid,
  input logic                             m_ready,
  input logic [7:0]                       m_data,
  input logic                             m_last,
  input logic                             cnt_en,
  input logic [$clog2(MAX_EVENTS+1)-1:0]  nev,
  input logic [31:0]                      bunch
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    nev <= ($clog2(MAX_EVENTS+1))'(MAX_EVENTS)); // R2
  AST_LAST_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |-> m_valid); // R2
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R9
  AST_BUNCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last) |=> (bunch == $past(bunch) + 32'd1)); // R8
  AST_STANDBY_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !m_valid) |=> (nev <= $past(nev))); // R5
  AST_SEND_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_last) |=> (nev == $past(nev))); // R10
endmodule

bind evt_bunch_packer ebp_checker #(.MAX_EVENTS(MAX_EVENTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .m_last(m_last), .cnt_en(cnt_en), .nev(nev_q), .bunch(bunch_q));

// File: tb/evt_bunch_packer_bench.sv
module evt_bunch_packer_bench;
  localparam int         MAXE = 4;
  localparam int         TMO  = 300;
  localparam logic [7:0] VER  = 8'h23;

  logic clk = 0, rst_n = 0;
  logic trig_stb = 0, busy_flag = 0, time_valid = 1, cnt_en = 0, m_ready = 0;
  logic [27:0] ts_tag8 = 0;
  logic [2:0]  ts_fine = 0;
  logic [25:0] clk_cnt = 0;
  logic [15:0] spi_data = 0, pps_cnt = 0, thr_ticks = 16'hFFFF;
  logic [31:0] ro_cnt = 0, busy_cnt = 0, secs = 0;
  logic        m_valid, m_last;
  logic [7:0]  m_data;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0]  rx [0:127];
  int          nrx;
  logic [95:0] exp_ev [0:7];
  int          nexp;
  logic [31:0] exp_ro = 0, exp_bz = 0, exp_sec = 0, bexp = 0;
  logic [15:0] exp_pps = 0;

  always #4 clk = ~clk;

  evt_bunch_packer #(.MAX_EVENTS(MAXE), .TIMEOUT_CYC(TMO), .VERSION(VER)) u_evt_bunch_packer (
    .clk(clk), .rst_n(rst_n), .trig_stb(trig_stb), .ts_tag8(ts_tag8), .ts_fine(ts_fine),
    .clk_cnt(clk_cnt), .spi_data(spi_data), .ro_cnt(ro_cnt), .busy_cnt(busy_cnt),
    .pps_cnt(pps_cnt), .secs(secs), .busy_flag(busy_flag), .time_valid(time_valid),
    .cnt_en(cnt_en), .thr_ticks(thr_ticks), .m_ready(m_ready), .m_valid(m_valid),
    .m_data(m_data), .m_last(m_last));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // caller stands at a negedge; returns at the next negedge
  task automatic fire(input logic [15:0] spi, input logic [31:0] ro, input logic [31:0] bz,
                      input logic [15:0] pps, input logic [31:0] sec, input logic bf,
                      input bit keep, input bit upd);
    logic [95:0] w;
    spi_data = spi; ro_cnt = ro; busy_cnt = bz; pps_cnt = pps; secs = sec; busy_flag = bf;
    ts_tag8 = 28'h0ABC000 + 28'(ro * 7); ts_fine = ro[2:0] ^ 3'd5;
    clk_cnt = 26'h1000000 + 26'(ro * 3);
    trig_stb = 1;
    if (keep) begin
      w = 96'(spi) << 80;
      w = w | (96'(ro[7:0]) << 72) | (96'(bz[7:0]) << 64);
      w = w | (96'(pps[1:0]) << 62) | (96'(sec[1:0]) << 60);
      w = w | (96'(bf) << 59) | (96'(time_valid) << 58);
      w = w | (96'(clk_cnt) << 32) | (96'(ts_tag8) << 4) | 96'(ts_fine);
      exp_ev[nexp] = w;
      nexp++;
    end
    if (upd) begin
      exp_ro = ro; exp_bz = bz; exp_pps = pps;
      if (!bf) exp_sec = sec;
    end
    @(negedge clk);
    trig_stb = 0;
  endtask

  task automatic recv(input bit bp, output int gap);
    int  cyc = 0;
    bit  fin = 0, hold = 0;
    logic [7:0] prev = 0;
    nrx = 0; gap = 0;
    while (!fin) begin
      @(negedge clk);
      m_ready = bp ? ((cyc % 3) != 1) : 1'b1;
      cyc++;
      if (hold) chk(m_valid && m_data == prev, "R9", "held byte", 160'(m_data), 160'(prev));
      hold = m_valid && !m_ready;
      prev = m_data;
      if (!m_valid && nrx == 0) gap++;
      if (m_valid && m_ready) begin
        if (nrx < 128) rx[nrx] = m_data;
        nrx++;
        if (m_last) fin = 1;
      end
    end
    @(posedge clk);
    #1 m_ready = 0;
  endtask

  task automatic check_bunch(input string req);
    logic [95:0]  w;
    logic [159:0] t, te;
    chk(nrx == nexp * 12 + 20, req, "byte count", 160'(nrx), 160'(nexp * 12 + 20));
    if (nrx == nexp * 12 + 20) begin
      for (int i = 0; i < nexp; i++) begin
        w = '0;
        for (int j = 0; j < 12; j++) w = (w << 8) | 96'(rx[i * 12 + j]);
        chk(w == exp_ev[i], req, "event word", 160'(w), 160'(exp_ev[i]));
      end
      t = '0;
      for (int j = 0; j < 20; j++) t = (t << 8) | 160'(rx[nexp * 12 + j]);
      te = (160'(bexp) << 128) | (160'(exp_ro) << 96) | (160'(exp_bz) << 64)
         | (160'(exp_pps) << 48) | (160'(exp_sec) << 16) | (160'(time_valid) << 15)
         | (160'(cnt_en) << 14) | 160'(VER);
      chk(t == te, req, "tailer", t, te);
    end
    bexp++;
    nexp = 0;
  endtask

  task automatic t_standby;  // R5 R4 R3 R8
    int gap;
    @(negedge clk);
    chk(!m_valid && !m_last, "R8", "reset outputs", 160'({m_valid, m_last}), 0);
    fire(16'h1111, 32'd77, 32'd5, 16'd9, 32'd400, 0, 0, 0);
    fire(16'h2222, 32'd78, 32'd6, 16'd9, 32'd400, 0, 0, 0);
    recv(0, gap);
    check_bunch("R5");
    recv(0, gap);
    chk(gap == TMO, "R4", "idle gap", 160'(gap), 160'(TMO));
    check_bunch("R4");
  endtask

  task automatic t_full;  // R1 R2 R3 R8
    int gap;
    @(negedge clk);
    cnt_en = 1;
    for (int i = 0; i < MAXE; i++)
      fire(16'hC000 + 16'(i), 32'h1000_0100 + i, 32'h2000_0010 + i, 16'h0A05 + 16'(i),
           32'h5555_0000 + i, 1'(i == 2), 1, 1);
    recv(0, gap);
    check_bunch("R2");
  endtask

  task automatic t_seconds;  // R7 R4
    int gap;
    @(negedge clk);
    fire(16'h0101, 32'd300, 32'd40, 16'd12, 32'd100, 0, 1, 1);
    fire(16'h0202, 32'd301, 32'd41, 16'd13, 32'd200, 1, 1, 1);
    recv(0, gap);
    chk(exp_sec == 32'd100, "R7", "bench model seconds", 160'(exp_sec), 160'd100);
    check_bunch("R7");
  endtask

  task automatic t_throttle;  // R6
    int gap;
    @(negedge clk);
    thr_ticks = 16'd5;
    fire(16'h3001, 32'd500, 32'd60, 16'd20, 32'd700, 0, 1, 1);
    repeat (4) @(negedge clk);
    fire(16'h3002, 32'd501, 32'd61, 16'd21, 32'd701, 0, 0, 1);  // k=5: dropped
    recv(0, gap);
    check_bunch("R6");
    @(negedge clk);
    fire(16'h3003, 32'd502, 32'd62, 16'd22, 32'd702, 0, 1, 1);
    repeat (5) @(negedge clk);
    fire(16'h3004, 32'd503, 32'd63, 16'd23, 32'd703, 0, 1, 1);  // k=6: kept
    recv(0, gap);
    check_bunch("R6");
    thr_ticks = 16'hFFFF;
  endtask

  task automatic t_backpressure;  // R9
    int gap;
    @(negedge clk);
    for (int i = 0; i < 3; i++)
      fire(16'h7700 + 16'(i), 32'd900 + i, 32'd80 + i, 16'd30, 32'd800 + i, 0, 1, 1);
    recv(1, gap);
    check_bunch("R9");
  endtask

  task automatic t_edge;  // R11 R10
    int gap;
    repeat (TMO) @(negedge clk);
    fire(16'hE001, 32'd1200, 32'd90, 16'd40, 32'd950, 0, 1, 1);  // on expiry cycle
    fire(16'hE002, 32'd1201, 32'd91, 16'd41, 32'd951, 0, 0, 0);  // first send cycle
    recv(0, gap);
    check_bunch("R11");
    recv(0, gap);
    chk(gap == TMO, "R10", "idle gap after edge", 160'(gap), 160'(TMO));
    check_bunch("R10");
  endtask

  initial begin
    nexp = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_standby();
    t_full();
    t_seconds();
    t_throttle();
    t_backpressure();
    t_edge();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule